// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Unit

This block is the hazard control for an in-order integer pipeline with six stages: fetch, issue, decode, execute, memory and write. Operand registers are read in decode and written back in write. The block keeps a small record of the two instructions in front of decode, one in execute and one in memory. For each source operand of the instruction in decode, it compares the register number with the destinations in that record. From these comparisons it picks the bypass path that the operand uses once the instruction reaches execute.

When a forward cannot cover the hazard, the block holds the front of the pipe and sends a no-op into execute. This happens when the register comes from a load that is in execute right now. It also happens when the multiplier's first stage is still occupied and a new multiply arrives, or when the load/store unit is still working through a block transfer and a new load arrives. The datapath obeys the returned selects: it reads the register file, the execute-stage result that now sits in the memory slot, or the memory-stage result that now sits in the write slot. There are three operands per instruction: two ALU sources, and the store data, which is read in execute.

Top module: `hzd_ilk_fwd`

## Requirements
- R1: After reset, `hold_front` and `bubble_ex` are low when decode holds no valid instruction, and every `fwd_sel` field reads 0.
- R2: `fwd_sel` encodes each operand in 2 bits: 0 means the register file, 1 means the result of the instruction one ahead, 2 means the result of the instruction two ahead. The value 3 never appears. One cycle after a decode that is not stalled, an operand whose register equals the destination of a write-enabled, non-load instruction in execute reads 1.
- R3: One cycle after a decode that is not stalled, an operand whose register matches only the write-enabled instruction in memory reads 2.
- R4: When both the execute and the memory instruction write the operand's register, the execute one wins and the field reads 1.
- R5: A match counts only when the producer's write enable is set and the operand's use bit is set. Register 0 is an ordinary register. An operand that does not match reads 0.
- R6: When a used operand matches a write-enabled load in execute, `hold_front` and `bubble_ex` are high in that same cycle. The stall lasts exactly one cycle. On the retry the operand reads 2, one cycle later.
- R7: A valid multiply in decode while `mul_s1_busy` is high raises `hold_front` and `bubble_ex`.
- R8: A valid load in decode while `lsu_multi_busy` is high raises `hold_front` and `bubble_ex`. A non-load is not held by that signal.
- R9: In the cycle after a stall, every `fwd_sel` field is 0, because the inserted bubble writes no register. The bubble is therefore never a forwarding source.
- R10: The store-data operand (index 2) takes part in forwarding and in the load interlock in the same way as the ALU operands.
- R11: With `dec_valid` low there is no stall, and execute receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_src | input | NSRC*RW | Source register numbers, operand 0 = A, 1 = B, 2 = store data |
| dec_src_use | input | NSRC | Operand actually read |
| dec_dst | input | RW | Destination register of the decode instruction |
| dec_dst_we | input | 1 | Decode instruction writes its destination |
| dec_is_load | input | 1 | Decode instruction is a load |
| dec_is_mul | input | 1 | Decode instruction is a multiply |
| lsu_multi_busy | input | 1 | Load/store unit still running a block transfer |
| mul_s1_busy | input | 1 | Multiplier first stage occupied |
| hold_front | output | 1 | Hold fetch, issue and decode this cycle |
| bubble_ex | output | 1 | Load a no-op into execute at the next edge |
| fwd_sel | output | NSRC*2 | Per-operand bypass select for the instruction now in execute |

## Verification
If the execute or memory record is stale or shifted by a stage, the error shows at the ports one cycle after the affected decode. A select points at the wrong path, for example 2 where 1 is due, or a bypass is reported from a bubble. A damaged load flag shows at once: `hold_front` goes missing, or is raised for nothing, in the very cycle the consumer sits in decode. A mistake in the structural interlock shows in that same cycle as a hold that does not track the busy inputs.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Bypass source for one operand, as seen by the instruction in execute
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,   // register file value read in decode
        FWD_EX  = 2'b01,   // result of the instruction one ahead (now in memory)
        FWD_MEM = 2'b10    // result of the instruction two ahead (now in write)
    } fwd_sel_e;

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid,
    input  logic [RW-1:0] src,
    input  logic          src_use,
    input  logic          ex_v,
    input  logic          ex_we,
    input  logic          ex_ld,
    input  logic [RW-1:0] ex_rd,
    input  logic          mem_v,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rd,
    output fwd_sel_e      sel,
    output logic          ld_hit
);

    logic live;
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        live    = dec_valid && src_use;
        ex_hit  = ex_v && ex_we && (ex_rd == src);
        mem_hit = mem_v && mem_we && (mem_rd == src);
        ld_hit  = live && ex_hit && ex_ld;
        if (!live)        sel = FWD_RF;
        else if (ex_hit)  sel = FWD_EX;
        else if (mem_hit) sel = FWD_MEM;
        else              sel = FWD_RF;
    end

    AST_YOUNGER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ex_v && ex_we && ex_rd == src && mem_v && mem_we && mem_rd == src)
        |-> (sel == FWD_EX)); // R4

    AST_NO_WE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ex_v && ex_we) && !(mem_v && mem_we)) |-> (sel == FWD_RF)); // R5

endmodule

// File: rtl/hzd_struct_chk.sv
module hzd_struct_chk (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_is_load,
    input  logic dec_is_mul,
    input  logic lsu_multi_busy,
    input  logic mul_s1_busy,
    output logic struct_stall
);

    logic mul_wait;
    logic lsu_wait;

    always_comb begin
        mul_wait     = dec_valid && dec_is_mul && mul_s1_busy;
        lsu_wait     = dec_valid && dec_is_load && lsu_multi_busy;
        struct_stall = mul_wait || lsu_wait;
    end

    AST_MUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_mul && mul_s1_busy) |-> struct_stall); // R7

    AST_LSU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_is_load && lsu_multi_busy) |-> struct_stall); // R8

endmodule

// File: rtl/hzd_ilk_fwd.sv
module hzd_ilk_fwd
    import hzd_pkg::*;
#(
    parameter int RW   = 4,
    parameter int NSRC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dec_valid,
    input  logic [NSRC-1:0][RW-1:0]    dec_src,
    input  logic [NSRC-1:0]            dec_src_use,
    input  logic [RW-1:0]              dec_dst,
    input  logic                       dec_dst_we,
    input  logic                       dec_is_load,
    input  logic                       dec_is_mul,
    input  logic                       lsu_multi_busy,
    input  logic                       mul_s1_busy,
    output logic                       hold_front,
    output logic                       bubble_ex,
    output logic [NSRC-1:0][1:0]       fwd_sel
);

    localparam int SELW = $bits(fwd_sel_e);

    typedef struct packed {
        logic          v;
        logic          we;
        logic          ld;
        logic [RW-1:0] rd;
    } slot_t;

    typedef struct packed {
        slot_t                     ex;
        slot_t                     mem;
        logic [NSRC-1:0][SELW-1:0] fwd;
    } state_t;

    state_t          st_d, st_q;
    logic [NSRC-1:0] ld_hit;
    fwd_sel_e        sel [NSRC];
    logic            struct_stall;
    logic            stall;
    logic            lu_any;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_src_match #(.RW(RW)) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .dec_valid (dec_valid),
            .src       (dec_src[g]),
            .src_use   (dec_src_use[g]),
            .ex_v      (st_q.ex.v),
            .ex_we     (st_q.ex.we),
            .ex_ld     (st_q.ex.ld),
            .ex_rd     (st_q.ex.rd),
            .mem_v     (st_q.mem.v),
            .mem_we    (st_q.mem.we),
            .mem_rd    (st_q.mem.rd),
            .sel       (sel[g]),
            .ld_hit    (ld_hit[g])
        );
    end

    hzd_struct_chk u_struct (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_valid      (dec_valid),
        .dec_is_load    (dec_is_load),
        .dec_is_mul     (dec_is_mul),
        .lsu_multi_busy (lsu_multi_busy),
        .mul_s1_busy    (mul_s1_busy),
        .struct_stall   (struct_stall)
    );

    assign lu_any = |ld_hit;
    assign stall  = lu_any | struct_stall;

    always_comb begin
        st_d     = st_q;
        st_d.mem = st_q.ex;
        if (stall || !dec_valid) begin
            st_d.ex = '0;
        end else begin
            st_d.ex.v  = 1'b1;
            st_d.ex.we = dec_dst_we;
            st_d.ex.ld = dec_is_load;
            st_d.ex.rd = dec_dst;
        end
        for (int i = 0; i < NSRC; i++) begin
            st_d.fwd[i] = stall ? FWD_RF : sel[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_front = stall;
    assign bubble_ex  = stall;
    assign fwd_sel    = st_q.fwd;

    AST_LU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lu_any) |-> !lu_any); // R6

    AST_BUBBLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall) |-> (fwd_sel == '0)); // R9

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !hold_front); // R11

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel[g] != 2'b11); // R2
    end

endmodule

// File: tb/test_hzd_ilk_fwd.sv
module test_hzd_ilk_fwd;
    localparam int RW = 4;
    localparam int NSRC = 3;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic [NSRC-1:0][RW-1:0] dec_src = '0;
    logic [NSRC-1:0] dec_src_use = '0;
    logic [RW-1:0] dec_dst = '0;
    logic dec_dst_we = 1'b0, dec_is_load = 1'b0, dec_is_mul = 1'b0;
    logic lsu_multi_busy = 1'b0, mul_s1_busy = 1'b0;
    logic hold_front, bubble_ex;
    logic [NSRC-1:0][1:0] fwd_sel;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // bench model of the two slots in front of decode
    logic          m_ex_v = 0, m_ex_we = 0, m_ex_ld = 0;
    logic [RW-1:0] m_ex_rd = '0;
    logic          m_mem_v = 0, m_mem_we = 0;
    logic [RW-1:0] m_mem_rd = '0;
    logic [1:0]    exp_sel [NSRC];
    string         exp_tag [NSRC];
    logic          last_stall = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_ilk_fwd #(.RW(RW), .NSRC(NSRC)) i_hzd_ilk_fwd (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .dec_src_use(dec_src_use), .dec_dst(dec_dst), .dec_dst_we(dec_dst_we),
        .dec_is_load(dec_is_load), .dec_is_mul(dec_is_mul),
        .lsu_multi_busy(lsu_multi_busy), .mul_s1_busy(mul_s1_busy),
        .hold_front(hold_front), .bubble_ex(bubble_ex), .fwd_sel(fwd_sel)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit ex_match(input logic [RW-1:0] r);
        return m_ex_v && m_ex_we && m_ex_rd == r;
    endfunction

    function automatic bit mem_match(input logic [RW-1:0] r);
        return m_mem_v && m_mem_we && m_mem_rd == r;
    endfunction

    function automatic bit ref_stall(output string tag);
        bit s = 0;
        tag = dec_valid ? "R5 no hazard" : "R11 idle decode";
        if (dec_valid) begin
            for (int i = 0; i < NSRC; i++)
                if (dec_src_use[i] && ex_match(dec_src[i]) && m_ex_ld) begin
                    s = 1; tag = (i == 2) ? "R10 store-data load-use" : "R6 load-use";
                end
            if (dec_is_mul && mul_s1_busy) begin s = 1; tag = "R7 multiplier busy"; end
            if (dec_is_load && lsu_multi_busy) begin s = 1; tag = "R8 block transfer busy"; end
            if (!dec_is_load && lsu_multi_busy && !s) tag = "R8 non-load not held";
        end
        return s;
    endfunction

    // one clock: drive at negedge (done by caller), check comb, advance model, check registered
    task automatic cycle();
        string tg;
        bit es;
        #1;
        es = ref_stall(tg);
        check(hold_front == es, tg, hold_front, es);
        check(bubble_ex == es, tg, bubble_ex, es);
        for (int i = 0; i < NSRC; i++) begin
            bit eh = dec_valid && dec_src_use[i] && ex_match(dec_src[i]);
            bit mh = dec_valid && dec_src_use[i] && mem_match(dec_src[i]);
            if (es) begin exp_sel[i] = 2'd0; exp_tag[i] = "R9 bubble after stall"; end
            else if (eh && mh) begin exp_sel[i] = 2'd1; exp_tag[i] = "R4 execute over memory"; end
            else if (eh) begin exp_sel[i] = 2'd1; exp_tag[i] = "R2 execute forward"; end
            else if (mh) begin
                exp_sel[i] = 2'd2;
                exp_tag[i] = last_stall ? "R6 retry after load-use" : "R3 memory forward";
            end
            else begin exp_sel[i] = 2'd0; exp_tag[i] = "R5 register file"; end
            if (i == 2 && exp_sel[i] != 0) exp_tag[i] = {"R10 store data / ", exp_tag[i]};
        end
        @(posedge clk);
        m_mem_v = m_ex_v; m_mem_we = m_ex_we; m_mem_rd = m_ex_rd;
        if (es || !dec_valid) begin
            m_ex_v = 0; m_ex_we = 0; m_ex_ld = 0; m_ex_rd = '0;
        end else begin
            m_ex_v = 1; m_ex_we = dec_dst_we; m_ex_ld = dec_is_load; m_ex_rd = dec_dst;
        end
        last_stall = es;
        @(negedge clk);
        for (int i = 0; i < NSRC; i++)
            check(fwd_sel[i] == exp_sel[i], exp_tag[i], fwd_sel[i], exp_sel[i]);
    endtask

    task automatic drive(input bit v, input int a, input int b, input int s, input bit [2:0] use_,
                         input int d, input bit we, input bit ld, input bit mul,
                         input bit lb, input bit mb);
        dec_valid = v; dec_src[0] = a[RW-1:0]; dec_src[1] = b[RW-1:0]; dec_src[2] = s[RW-1:0];
        dec_src_use = use_; dec_dst = d[RW-1:0]; dec_dst_we = we; dec_is_load = ld;
        dec_is_mul = mul; lsu_multi_busy = lb; mul_s1_busy = mb;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(hold_front == 0, "R1 reset hold", hold_front, 0);
        check(fwd_sel == '0, "R1 reset selects", fwd_sel, 0);
        // R2 / R3: producer r2, then consumer A=r2, then consumer B=r2 two later
        drive(1, 0, 0, 0, 3'b000, 2, 1, 0, 0, 0, 0);
        drive(1, 2, 5, 0, 3'b011, 7, 1, 0, 0, 0, 0);
        drive(1, 9, 2, 0, 3'b010, 8, 0, 0, 0, 0, 0);
        // R4: two writers of r0 back to back, consumer of r0 (R5 r0 ordinary)
        drive(1, 0, 0, 0, 3'b000, 0, 1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 3'b000, 0, 1, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 3'b111, 1, 1, 0, 0, 0, 0);
        // R5: producer without write enable, unused operand
        drive(1, 0, 0, 0, 3'b000, 4, 0, 0, 0, 0, 0);
        drive(1, 4, 4, 4, 3'b111, 3, 1, 0, 0, 0, 0);
        drive(1, 3, 0, 3, 3'b000, 5, 1, 0, 0, 0, 0);
        // R6 / R10: load r6, store-data consumer stalls once then forwards from memory
        drive(1, 0, 0, 0, 3'b000, 6, 1, 1, 0, 0, 0);
        drive(1, 1, 1, 6, 3'b100, 0, 0, 0, 0, 0, 0);
        drive(1, 1, 1, 6, 3'b100, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0);
        // R7 / R8 structural holds, non-load under lsu busy
        drive(1, 0, 0, 0, 3'b000, 1, 1, 0, 1, 0, 1);
        drive(1, 0, 0, 0, 3'b000, 1, 1, 1, 0, 1, 0);
        drive(1, 0, 0, 0, 3'b000, 1, 1, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 3'b000, 0, 0, 0, 0, 0, 0);
        // random mix over a small register range to provoke hazards
        for (int n = 0; n < 4000; n++) begin
            if (!last_stall || ($urandom % 8) == 0) begin
                dec_valid = ($urandom % 8) != 0;
                for (int i = 0; i < NSRC; i++) dec_src[i] = RW'($urandom % 4);
                dec_src_use = 3'($urandom);
                dec_dst = RW'($urandom % 4);
                dec_dst_we = ($urandom % 4) != 0;
                dec_is_load = ($urandom % 4) == 0;
                dec_is_mul = !dec_is_load && ($urandom % 5) == 0;
            end
            lsu_multi_busy = ($urandom % 5) == 0;
            mul_s1_busy = ($urandom % 5) == 0;
            cycle();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule